// File: doc/BRIEF.md
# USB Controller Suspend and Wake Manager

This block tracks the power state of the two controllers in a dual-role USB chip: a host controller and a peripheral controller. Each one is suspended and woken without regard to the other. The host goes to sleep when software writes the operational code and then the suspend code to its control register. Three sources can wake it: a low pulse of sufficient length on its combined suspend/wake pin, a similar low pulse on chip select, or a resume indication from the downstream port. The peripheral controller is suspended on request and is woken by a low pulse on its own suspend/wake pin.

A wake gives the host only a limited clock window. Software must write the operational code before the window runs out. If it does not, the host drops back into suspend by itself. The shared clock and PLL enable is removed only while both controllers are asleep. It stays on while either controller is awake or inside a wake window.

Top module: `swm_top`

## Requirements
- R1: After reset, the host is operational, the peripheral is awake and `clk_pll_en_o` is 1.
- R2: When a write of 0x06C0 directly follows a write of 0x0680 on the control write port, `host_suspended_o` goes to 1 on the clock edge after the 0x06C0 write.
- R3: A write of 0x06C0 has no effect unless the write just before it carried 0x0680. This includes a 0x06C0 write as the first write after reset.
- R4: Each wake pin passes through a two-flop synchronizer. While the host is suspended, a low level on `host_wake_ni` sampled on at least MIN_LOW_CYC consecutive clock edges wakes the host. A shorter low pulse is ignored.
- R5: Chip select `cs_ni` is qualified by the same rule as R4 and wakes a suspended host.
- R6: While the host is suspended, a one-cycle high on `port_resume_i` wakes the host, and `host_suspended_o` falls on the next edge.
- R7: After a wake, the host stays awake for exactly WAKE_WIN_CYC cycles. If no 0x0680 write arrives within that window, it returns to suspend.
- R8: A write of 0x0680 during the wake window makes the host permanently operational. The host then stays awake after the window would have ended.
- R9: Wake requests from any source are ignored while the host is operational. They do not start a wake window.
- R10: A one-cycle `dev_suspend_req_i` suspends the peripheral and leaves the host state untouched.
- R11: A low pulse on `dev_wake_ni` wakes a suspended peripheral, under the same qualification rule as R4.
- R12: `clk_pll_en_o` is 0 only while both the host and the peripheral are suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Host control register write strobe |
| reg_wdata_i | input | 16 | Host control register write data |
| host_wake_ni | input | 1 | Host suspend/wake pin, asynchronous, low requests wake |
| cs_ni | input | 1 | Chip select, asynchronous, a low pulse wakes the host |
| port_resume_i | input | 1 | Synchronous resume indication from the downstream port |
| dev_suspend_req_i | input | 1 | One-cycle request to suspend the peripheral |
| dev_wake_ni | input | 1 | Peripheral suspend/wake pin, asynchronous, low requests wake |
| host_suspended_o | output | 1 | Host controller is suspended |
| dev_suspended_o | output | 1 | Peripheral controller is suspended |
| clk_pll_en_o | output | 1 | Shared clock and PLL enable |

## Verification
The assertions assume the following about the inputs:
- `port_resume_i`, `reg_wr_i` and `reg_wdata_i` are synchronous to `clk_i`.
- Write strobes last one cycle.
- MIN_LOW_CYC is at least 2.

The stimulus changes every input on the falling clock edge and holds each strobe for exactly one cycle. Pin pulses are whole numbers of cycles, chosen one short of the threshold and exactly at it. The wake window is shortened by a parameter so that the expiry can be checked at its exact cycle.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam logic [15:0] CODE_OPER = 16'h0680;
  localparam logic [15:0] CODE_SUSP = 16'h06C0;

  typedef enum logic [1:0] {
    HS_OPER = 2'd0,
    HS_SUSP = 2'd1,
    HS_WAKE = 2'd2
  } host_st_e;
endpackage

// File: rtl/swm_low_qual.sv
module swm_low_qual #(
  parameter int MIN_LOW_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fire_o
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
  end

  assign low = ~sync_q[SYNC_STAGES-1];

  // saturating count of consecutive low samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!low)                      run_q <= '0;
    else if (run_q != CW'(MIN_LOW_CYC)) run_q <= run_q + 1'b1;
  end

  assign fire_o = low && (run_q == CW'(MIN_LOW_CYC - 1));

  generate
    if (MIN_LOW_CYC >= 2) begin : g_chk
      // R4
      low_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> (!sync_q[SYNC_STAGES-1] && $past(!sync_q[SYNC_STAGES-1])));
    end
  endgenerate
endmodule

// File: rtl/swm_host_fsm.sv
module swm_host_fsm
  import swm_pkg::*;
#(
  parameter int WAKE_WIN_CYC = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        wake_i,
  output logic        suspended_o
);
  localparam int WW = $clog2(WAKE_WIN_CYC);

  host_st_e      st_q, st_d;
  logic          armed_q;
  logic [WW-1:0] win_q;
  logic          wr_oper, wr_susp, win_end;

  assign wr_oper = wr_i && (wdata_i == CODE_OPER);
  assign wr_susp = wr_i && (wdata_i == CODE_SUSP);
  assign win_end = (win_q == WW'(WAKE_WIN_CYC - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_OPER: if (wr_susp && armed_q) st_d = HS_SUSP;
      HS_SUSP: if (wake_i)             st_d = HS_WAKE;
      HS_WAKE: if (wr_oper)            st_d = HS_OPER;
               else if (win_end)       st_d = HS_SUSP;
      default:                         st_d = HS_OPER;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HS_OPER;
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      st_q <= st_d;
      if (wr_i) armed_q <= wr_oper;
      if (st_q == HS_WAKE) win_q <= win_q + 1'b1;
      else                 win_q <= '0;
    end
  end

  assign suspended_o = (st_q == HS_SUSP);

  // R2
  cmd_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_OPER && wr_susp && armed_q) |=> suspended_o);
  // R6
  wake_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_SUSP && wake_i) |=> (st_q == HS_WAKE));
  // R7
  win_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_WAKE && win_end && !wr_oper) |=> suspended_o);
  // R8
  win_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_WAKE && wr_oper) |=> (st_q == HS_OPER));
  // R9
  no_wake_when_oper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HS_OPER) |=> (st_q != HS_WAKE));
endmodule

// File: rtl/swm_dev_ctl.sv
module swm_dev_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic suspend_req_i,
  input  logic wake_i,
  output logic suspended_o
);
  logic susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      susp_q <= 1'b0;
    else if (susp_q && wake_i)        susp_q <= 1'b0;
    else if (!susp_q && suspend_req_i) susp_q <= 1'b1;
  end

  assign suspended_o = susp_q;

  // R11
  dev_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && wake_i) |=> !suspended_o);
endmodule

// File: rtl/swm_top.sv
module swm_top #(
  parameter int MIN_LOW_CYC  = 3,
  parameter int WAKE_WIN_CYC = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  input  logic        host_wake_ni,
  input  logic        cs_ni,
  input  logic        port_resume_i,
  input  logic        dev_suspend_req_i,
  input  logic        dev_wake_ni,
  output logic        host_suspended_o,
  output logic        dev_suspended_o,
  output logic        clk_pll_en_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pins_n, fire;
  logic            host_wake;

  assign pins_n = {dev_wake_ni, cs_ni, host_wake_ni};

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_qual
      swm_low_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_ni (pins_n[i]),
        .fire_o (fire[i])
      );
    end
  endgenerate

  assign host_wake = fire[0] | fire[1] | port_resume_i;

  swm_host_fsm #(.WAKE_WIN_CYC(WAKE_WIN_CYC)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .wake_i      (host_wake),
    .suspended_o (host_suspended_o)
  );

  swm_dev_ctl u_dev (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .suspend_req_i (dev_suspend_req_i),
    .wake_i        (fire[2]),
    .suspended_o   (dev_suspended_o)
  );

  assign clk_pll_en_o = ~(host_suspended_o & dev_suspended_o);

  // R12
  clk_on_when_dev_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_suspended_o |-> clk_pll_en_o);
  // R10
  dev_req_keeps_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_suspend_req_i && !reg_wr_i && !host_wake) |=> $stable(host_suspended_o));
endmodule

// File: tb/swm_top_test.sv
module swm_top_test;
  localparam int MINL = 3;
  localparam int WIN  = 40;
  localparam int SETTLE = 8;
  localparam int NV = 16;

  // op[31:28] arg[27:12] exp {host_susp, dev_susp, clk_en}[2:0]
  // ops: 0 write, 1 host pin pulse, 2 cs pulse, 3 resume, 4 dev suspend, 5 dev pin pulse, 6 idle
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 16'h0680, 9'd0, 3'b001},  // R2 arm
    {4'd0, 16'h06C0, 9'd0, 3'b101},  // R2 suspend
    {4'd1, 16'd2,    9'd0, 3'b101},  // R4 short ignored
    {4'd1, 16'd3,    9'd0, 3'b001},  // R4 wake
    {4'd0, 16'h0680, 9'd0, 3'b001},  // R8 cancel
    {4'd6, 16'd50,   9'd0, 3'b001},  // R8 stays operational
    {4'd0, 16'h06C0, 9'd0, 3'b101},  // R2 rearmed by last write
    {4'd2, 16'd2,    9'd0, 3'b101},  // R5 short ignored
    {4'd2, 16'd3,    9'd0, 3'b001},  // R5 wake
    {4'd6, 16'd50,   9'd0, 3'b101},  // R7 fallback
    {4'd3, 16'd0,    9'd0, 3'b001},  // R6 resume
    {4'd6, 16'd50,   9'd0, 3'b101},  // R7 fallback
    {4'd4, 16'd0,    9'd0, 3'b110},  // R10 R12 both asleep
    {4'd5, 16'd2,    9'd0, 3'b110},  // R11 short ignored
    {4'd5, 16'd3,    9'd0, 3'b101},  // R11 R12 wake peripheral
    {4'd0, 16'h1234, 9'd0, 3'b101}   // R3 unrelated write
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, hw_n = 1'b1, cs_n = 1'b1, res = 1'b0, dreq = 1'b0, dw_n = 1'b1;
  logic [15:0] wdata = '0;
  logic hs, ds, ce;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swm_top #(.MIN_LOW_CYC(MINL), .WAKE_WIN_CYC(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .host_wake_ni(hw_n), .cs_ni(cs_n), .port_resume_i(res),
    .dev_suspend_req_i(dreq), .dev_wake_ni(dw_n),
    .host_suspended_o(hs), .dev_suspended_o(ds), .clk_pll_en_o(ce)
  );

  task automatic chk(string tag, logic [2:0] exp);
    n_chk++;
    if ({hs, ds, ce} !== exp) begin
      n_fail++;
      $display("FAIL %s: {host,dev,clk} actual %b expected %b", tag, {hs, ds, ce}, exp);
    end
  endtask

  task automatic wr_reg(logic [15:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_op(logic [3:0] op, logic [15:0] arg);
    @(negedge clk);
    case (op)
      4'd0: begin wr = 1'b1; wdata = arg; @(negedge clk); wr = 1'b0; end
      4'd1: begin hw_n = 1'b0; repeat (int'(arg)) @(negedge clk); hw_n = 1'b1; end
      4'd2: begin cs_n = 1'b0; repeat (int'(arg)) @(negedge clk); cs_n = 1'b1; end
      4'd3: begin res = 1'b1; @(negedge clk); res = 1'b0; end
      4'd4: begin dreq = 1'b1; @(negedge clk); dreq = 1'b0; end
      4'd5: begin dw_n = 1'b0; repeat (int'(arg)) @(negedge clk); dw_n = 1'b1; end
      default: repeat (int'(arg)) @(negedge clk);
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  initial begin
    do_reset();
    chk("R1 reset state", 3'b001);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][31:28], VEC[i][27:12]);
      idle(SETTLE);
      chk($sformatf("vector %0d", i), VEC[i][2:0]);
    end

    // R3: suspend code without preceding operational code
    do_reset();
    wr_reg(16'h06C0); idle(2);
    chk("R3 first write suspend code", 3'b001);
    wr_reg(16'h0680); wr_reg(16'h1234); wr_reg(16'h06C0); idle(2);
    chk("R3 broken sequence", 3'b001);

    // R9: wake sources while operational do not open a window
    run_op(4'd1, 16'd5); run_op(4'd2, 16'd5); run_op(4'd3, 16'd0);
    idle(WIN + 20);
    chk("R9 wake ignored while operational", 3'b001);

    // R7: exact window length
    wr_reg(16'h0680); wr_reg(16'h06C0); idle(1);
    chk("R2 suspended before window test", 3'b101);
    @(negedge clk); res = 1'b1;
    @(negedge clk); res = 1'b0;
    idle(WIN - 1);
    chk("R7 last cycle of window", 3'b001);
    idle(1);
    chk("R7 suspended after window", 3'b101);

    // R8: late cancel on second-to-last cycle
    @(negedge clk); res = 1'b1;
    @(negedge clk); res = 1'b0;
    idle(WIN - 3);
    wr_reg(16'h0680); idle(WIN);
    chk("R8 late cancel holds", 3'b001);

    // R10: peripheral suspend leaves operational host alone
    run_op(4'd4, 16'd0); idle(2);
    chk("R10 peripheral only", 3'b011);
    // R12: host asleep too stops clock
    wr_reg(16'h0680); wr_reg(16'h06C0); idle(1);
    chk("R12 both asleep", 3'b110);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule